// File: doc/BRIEF.md
# Fault Escalation and Shutdown Controller

This block watches the faults raised while one instruction executes and decides how each is delivered. A fault request arrives as a one-hot-per-vector bitmap, with an optional selector index beside it. When several bits are set in one cycle, the lowest-numbered vector is taken. A fault normally goes to dispatch unchanged. A second fault that follows a contributory first fault (vector 0, 10, 11, 12 or 13) before the instruction retires is turned into a double fault (vector 8). Any fault raised while the double fault is being handled drives the core into shutdown. On entry to shutdown the block requests a halt bus cycle with address bit 1 low.

In shutdown, every fault request and retire strobe is ignored. An NMI leaves shutdown: vector 2 is dispatched and protected mode stays as it was. The NMI handler then runs under watch. Any fault before the next retire strobe sends the core back to shutdown. RESET leaves every state, shutdown included, and clears the protected-mode flag. The pm_enter strobe sets that flag. All outputs come from registers and change on the clock edge after the input that causes them.

The controller has five states. ST_RUN: no contributory fault is pending. ST_FIRST: a contributory fault was dispatched in this instruction. ST_DOUBLE: a double fault was dispatched. ST_SHUT: shutdown. ST_NMI: the NMI handler is running after shutdown. Its transitions are:
- run_to_first: contributory fault in ST_RUN.
- first_to_double: any fault in ST_FIRST.
- double_to_shut: any fault in ST_DOUBLE.
- shut_to_nmi: NMI in ST_SHUT.
- nmi_to_shut: any fault in ST_NMI.
- retire_to_run: retire with no fault, from ST_FIRST, ST_DOUBLE or ST_NMI.
- reset_to_run: RESET, from any state.

Top module: `fault_escalator`

## Requirements
- R1: While and after RESET, with no other input active: disp_valid=0, err_present=0, err_code=0, shutdown=0, halt_req=0, halt_a1=1, prot_mode=0.
- R2: When several bits of flt_req are set in one cycle, exactly one dispatch occurs one cycle later, and disp_vec is the index of the lowest set bit.
- R3: After a contributory fault (vector 0, 10, 11, 12 or 13) has been dispatched, any fault request before the next retire dispatches vector 8 instead of the requested vector.
- R4: A fault that follows a dispatched benign fault (any vector other than 0 and 10 to 13) in the same instruction is dispatched as its own vector.
- R5: A retire strobe with no fault request ends the instruction. A fault that follows it is dispatched as its own vector, even if the previous instruction raised a contributory fault.
- R6: err_present=1 only with vectors 8 and 10 to 13. For 10 to 13, err_code bits 15:3 hold flt_sel when flt_sel_ok=1, bits 2:0 are 0, and the whole code is 0 when flt_sel_ok=0. Vector 8 carries err_code 0. All other vectors, vector 6 among them, give err_present=0 and err_code=0.
- R7: A fault request after a double-fault dispatch and before retire sets shutdown=1 with no dispatch. It also raises halt_req for exactly one cycle with halt_a1=0.
- R8: While shutdown=1, fault requests and retire strobes cause no dispatch and no halt request, and shutdown stays 1.
- R9: NMI during shutdown clears shutdown and dispatches vector 2 with prot_mode unchanged. A fault before the following retire returns to shutdown with a new halt request. A retire first returns to normal operation.
- R10: pm_enter sets prot_mode. RESET clears prot_mode and shutdown from any state.
- R11: When a fault request and a retire strobe arrive in the same cycle, the fault is acted on first and the retire is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high RESET; leaves shutdown and clears protected mode |
| flt_req | input | NVEC | Fault request bitmap, one bit per vector |
| flt_sel | input | SELW | Selector index that goes with the fault request |
| flt_sel_ok | input | 1 | flt_sel is meaningful for this fault |
| retire | input | 1 | Instruction retire strobe |
| nmi | input | 1 | Non-maskable interrupt; acted on only in shutdown |
| pm_enter | input | 1 | Sets the protected-mode flag |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_vec | output | log2(NVEC) | Vector to dispatch |
| err_present | output | 1 | The dispatched vector pushes an error code |
| err_code | output | SELW+3 | Error code value |
| shutdown | output | 1 | Core is in shutdown |
| halt_req | output | 1 | Halt bus cycle request, one cycle on shutdown entry |
| halt_a1 | output | 1 | Address bit 1 for the halt cycle; 0 while halt_req is high |
| prot_mode | output | 1 | Protected-mode flag |

## Verification
The hardest situation to reach from the ports is a return to shutdown from the watched NMI handler. It takes a contributory fault, a second fault, a third fault, an NMI, and then a fault with no retire in between, in that exact order. The directed part of the bench walks this chain step by step. The random part draws fault vectors mostly from the contributory set and keeps retire rare, so chains of three or more faults within one instruction happen often. Every cycle is compared against a bench model of the state sequence.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_FIRST,
        ST_DOUBLE,
        ST_SHUT,
        ST_NMI
    } esc_state_t;

    localparam int VEC_NMI = 2;
    localparam int VEC_DF  = 8;

    // Vectors whose first occurrence arms double-fault escalation
    function automatic logic is_contrib(input int v);
        return (v == 0) || (v >= 10 && v <= 13);
    endfunction

    // Vectors that push an error code
    function automatic logic has_errcode(input int v);
        return (v == VEC_DF) || (v >= 10 && v <= 13);
    endfunction

    // Vectors whose error code carries a selector index
    function automatic logic has_selector(input int v);
        return v >= 10 && v <= 13;
    endfunction

endpackage

// File: rtl/fault_esc_prio.sv
module fault_esc_prio #(
    parameter  int NVEC = 32,
    localparam int VW   = $clog2(NVEC)
) (
    input  logic [NVEC-1:0] req,
    output logic            any,
    output logic [VW-1:0]   idx
);
    // Downward scan so the lowest set bit is written last and wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (req[i]) idx = VW'(i);
        end
    end
endmodule

// File: rtl/fault_esc_errfmt.sv
module fault_esc_errfmt
    import fault_esc_pkg::*;
#(
    parameter  int VW   = 5,
    parameter  int SELW = 13,
    localparam int ECW  = SELW + 3
) (
    input  logic [VW-1:0]   vec,
    input  logic [SELW-1:0] sel,
    input  logic            sel_ok,
    output logic            present,
    output logic [ECW-1:0]  code
);
    always_comb begin
        present = has_errcode(int'(vec));
        code    = '0;
        if (has_selector(int'(vec)) && sel_ok) code = {sel, 3'b000};
    end
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fault_esc_pkg::*;
#(
    parameter  int NVEC = 32,
    parameter  int SELW = 13,
    localparam int VW   = $clog2(NVEC),
    localparam int ECW  = SELW + 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NVEC-1:0] flt_req,
    input  logic [SELW-1:0] flt_sel,
    input  logic            flt_sel_ok,
    input  logic            retire,
    input  logic            nmi,
    input  logic            pm_enter,
    output logic            disp_valid,
    output logic [VW-1:0]   disp_vec,
    output logic            err_present,
    output logic [ECW-1:0]  err_code,
    output logic            shutdown,
    output logic            halt_req,
    output logic            halt_a1,
    output logic            prot_mode
);
    esc_state_t st, st_n;

    logic            req_any;
    logic [VW-1:0]   req_idx;
    logic            dv_n;
    logic [VW-1:0]   vec_n;
    logic            halt_n;
    logic            ef_present;
    logic [ECW-1:0]  ef_code;

    fault_esc_prio #(.NVEC(NVEC)) u_prio (
        .req (flt_req),
        .any (req_any),
        .idx (req_idx)
    );

    fault_esc_errfmt #(.VW(VW), .SELW(SELW)) u_errfmt (
        .vec     (vec_n),
        .sel     (flt_sel),
        .sel_ok  (flt_sel_ok),
        .present (ef_present),
        .code    (ef_code)
    );

    // Next-state and next-output decision; a fault outranks retire (R11)
    always_comb begin
        st_n   = st;
        dv_n   = 1'b0;
        vec_n  = req_idx;
        halt_n = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (req_any) begin
                    dv_n = 1'b1;
                    if (is_contrib(int'(req_idx))) st_n = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (req_any) begin
                    dv_n  = 1'b1;
                    vec_n = VW'(VEC_DF);
                    st_n  = ST_DOUBLE;
                end else if (retire) begin
                    st_n = ST_RUN;
                end
            end
            ST_DOUBLE, ST_NMI: begin
                if (req_any) begin
                    halt_n = 1'b1;
                    st_n   = ST_SHUT;
                end else if (retire) begin
                    st_n = ST_RUN;
                end
            end
            ST_SHUT: begin
                if (nmi) begin
                    dv_n  = 1'b1;
                    vec_n = VW'(VEC_NMI);
                    st_n  = ST_NMI;
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_RUN;
        else     st <= st_n;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            disp_valid  <= 1'b0;
            disp_vec    <= '0;
            err_present <= 1'b0;
            err_code    <= '0;
            shutdown    <= 1'b0;
            halt_req    <= 1'b0;
            halt_a1     <= 1'b1;
            prot_mode   <= 1'b0;
        end else begin
            disp_valid  <= dv_n;
            disp_vec    <= vec_n;
            err_present <= dv_n & ef_present;
            err_code    <= dv_n ? ef_code : '0;
            shutdown    <= (st_n == ST_SHUT);
            halt_req    <= halt_n;
            halt_a1     <= ~halt_n;
            prot_mode   <= prot_mode | pm_enter;
        end
    end
endmodule

// File: rtl/fault_esc_checker.sv
module fault_esc_checker #(
    parameter int VW  = 5,
    parameter int ECW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          disp_valid,
    input logic [VW-1:0] disp_vec,
    input logic          err_present,
    input logic [ECW-1:0] err_code,
    input logic          shutdown,
    input logic          halt_req,
    input logic          halt_a1,
    input logic          prot_mode
);
    assert_sd_no_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> !disp_valid);

    assert_halt_a1_low_R7: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (shutdown && !halt_a1));

    assert_halt_on_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(shutdown)) |-> halt_req);

    assert_halt_single_R7: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !halt_req);

    assert_df_zero_code_R6: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_vec == VW'(8)) |-> (err_present && err_code == '0));

    assert_ud_no_code_R6: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_vec == VW'(6)) |-> !err_present);

    assert_reset_clears_pm_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!prot_mode && !shutdown));

    assert_exit_via_nmi_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(shutdown)) |-> (disp_valid && disp_vec == VW'(2)));
endmodule

bind fault_escalator fault_esc_checker #(.VW(VW), .ECW(ECW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .disp_valid  (disp_valid),
    .disp_vec    (disp_vec),
    .err_present (err_present),
    .err_code    (err_code),
    .shutdown    (shutdown),
    .halt_req    (halt_req),
    .halt_a1     (halt_a1),
    .prot_mode   (prot_mode)
);

// File: tb/sim_fault_escalator.sv
`timescale 1ns/1ps
module sim_fault_escalator;
    localparam int NVEC = 32;
    localparam int SELW = 13;
    localparam int VW   = 5;
    localparam int ECW  = 16;

    localparam int S_RUN = 0, S_FIRST = 1, S_DBL = 2, S_SHUT = 3, S_NMI = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic [NVEC-1:0] flt_req;
    logic [SELW-1:0] flt_sel;
    logic            flt_sel_ok, retire, nmi, pm_enter;
    logic            disp_valid, err_present, shutdown, halt_req, halt_a1, prot_mode;
    logic [VW-1:0]   disp_vec;
    logic [ECW-1:0]  err_code;

    int n_tests = 0;
    int n_fail  = 0;

    // model state and expected outputs
    int m_st = S_RUN;
    int m_pm = 0;
    int e_dv, e_vec, e_ep, e_ec, e_sd, e_halt, e_a1, e_pm;

    always #2.5 clk = ~clk;

    fault_escalator u0 (
        .clk(clk), .rst(rst), .flt_req(flt_req), .flt_sel(flt_sel),
        .flt_sel_ok(flt_sel_ok), .retire(retire), .nmi(nmi), .pm_enter(pm_enter),
        .disp_valid(disp_valid), .disp_vec(disp_vec), .err_present(err_present),
        .err_code(err_code), .shutdown(shutdown), .halt_req(halt_req),
        .halt_a1(halt_a1), .prot_mode(prot_mode)
    );

    function automatic bit contrib(int v);
        return v == 0 || (v >= 10 && v <= 13);
    endfunction

    task automatic deliver(int v, int sl, bit sv);
        e_dv  = 1;
        e_vec = v;
        e_ep  = (v == 8 || (v >= 10 && v <= 13)) ? 1 : 0;
        e_ec  = (v >= 10 && v <= 13 && sv) ? sl * 8 : 0;
    endtask

    task automatic model(logic [NVEC-1:0] rq, int sl, bit sv, bit rt, bit nm, bit pe, bit rs);
        int lo = -1;
        for (int i = NVEC - 1; i >= 0; i--) if (rq[i]) lo = i;
        e_dv = 0; e_vec = 0; e_ep = 0; e_ec = 0; e_halt = 0;
        if (rs) begin
            m_st = S_RUN;
            m_pm = 0;
        end else begin
            if (pe) m_pm = 1;
            case (m_st)
                S_RUN:   if (lo >= 0) begin deliver(lo, sl, sv); if (contrib(lo)) m_st = S_FIRST; end
                S_FIRST: if (lo >= 0) begin deliver(8, sl, sv); m_st = S_DBL; end
                         else if (rt) m_st = S_RUN;
                S_DBL, S_NMI: if (lo >= 0) begin e_halt = 1; m_st = S_SHUT; end
                         else if (rt) m_st = S_RUN;
                S_SHUT:  if (nm) begin deliver(2, sl, sv); m_st = S_NMI; end
                default: m_st = S_RUN;
            endcase
        end
        e_sd = (m_st == S_SHUT) ? 1 : 0;
        e_a1 = e_halt ? 0 : 1;
        e_pm = m_pm;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "disp_valid", 32'(disp_valid), 32'(e_dv));
        if (e_dv != 0) chk(tag, "disp_vec", 32'(disp_vec), 32'(e_vec));
        chk(tag, "err_present", 32'(err_present), 32'(e_ep));
        chk(tag, "err_code", 32'(err_code), 32'(e_ec));
        chk(tag, "shutdown", 32'(shutdown), 32'(e_sd));
        chk(tag, "halt_req", 32'(halt_req), 32'(e_halt));
        chk(tag, "halt_a1", 32'(halt_a1), 32'(e_a1));
        chk(tag, "prot_mode", 32'(prot_mode), 32'(e_pm));
    endtask

    // Drive at the falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(string tag, logic [NVEC-1:0] rq, int sl, bit sv, bit rt, bit nm, bit pe, bit rs);
        flt_req = rq; flt_sel = SELW'(sl); flt_sel_ok = sv;
        retire = rt; nmi = nm; pm_enter = pe; rst = rs;
        model(rq, sl, sv, rt, nm, pe, rs);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [NVEC-1:0] bit_of(int v);
        return NVEC'(1) << v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int pool [8] = '{0, 10, 11, 12, 13, 1, 6, 14};
        seed = $urandom(32'd2024);
        flt_req = '0; flt_sel = '0; flt_sel_ok = 0; retire = 0; nmi = 0; pm_enter = 0; rst = 1;
        @(negedge clk);

        // R1 reset state
        step("R1", '0, 0, 0, 0, 0, 0, 1);
        step("R1", '0, 0, 0, 0, 0, 0, 1);
        step("R1", '0, 0, 0, 0, 0, 0, 0);
        chk("R1", "halt_a1 idle", 32'(halt_a1), 1);

        step("R10", '0, 0, 0, 0, 0, 1, 0);
        chk("R10", "prot_mode set", 32'(prot_mode), 1);

        // R2 lowest vector of several; vector 6 has no error code (R6)
        step("R2", bit_of(13) | bit_of(6) | bit_of(11), 9, 1, 0, 0, 0, 0);
        chk("R2", "lowest vector", 32'(disp_vec), 6);
        chk("R6", "vec6 no err", 32'(err_present), 0);

        // R4 benign then contributory: delivered as is
        step("R4", bit_of(14), 0, 0, 0, 0, 0, 0);
        step("R4", bit_of(13), 5, 1, 0, 0, 0, 0);
        chk("R4", "vec13 delivered", 32'(disp_vec), 13);
        chk("R6", "selector code", 32'(err_code), 40);

        // R3 contributory then another: double fault with zero code
        step("R3", bit_of(11), 7, 1, 0, 0, 0, 0);
        chk("R3", "double fault vec", 32'(disp_vec), 8);
        chk("R6", "df code zero", 32'(err_code), 0);

        // R7 + R11: fault with retire during double fault -> shutdown
        step("R11", bit_of(12), 0, 0, 1, 0, 0, 0);
        chk("R7", "halt_req", 32'(halt_req), 1);
        chk("R7", "halt_a1", 32'(halt_a1), 0);
        chk("R11", "shutdown", 32'(shutdown), 1);
        step("R7", '0, 0, 0, 0, 0, 0, 0);
        chk("R7", "halt one cycle", 32'(halt_req), 0);

        // R8 ignored in shutdown
        step("R8", bit_of(0), 0, 0, 1, 0, 0, 0);
        chk("R8", "no dispatch", 32'(disp_valid), 0);
        chk("R8", "still shutdown", 32'(shutdown), 1);

        // R9 NMI exit, then error during NMI handling
        step("R9", '0, 0, 0, 0, 1, 0, 0);
        chk("R9", "nmi vector", 32'(disp_vec), 2);
        chk("R9", "pm kept", 32'(prot_mode), 1);
        step("R9", bit_of(10), 0, 0, 0, 0, 0, 0);
        chk("R9", "back to shutdown", 32'(shutdown), 1);
        chk("R9", "halt again", 32'(halt_req), 1);
        step("R9", '0, 0, 0, 0, 1, 0, 0);
        step("R9", '0, 0, 0, 1, 0, 0, 0);

        // R5 retire separates instructions
        step("R5", bit_of(10), 3, 1, 0, 0, 0, 0);
        chk("R6", "vec10 code", 32'(err_code), 24);
        step("R5", '0, 0, 0, 1, 0, 0, 0);
        step("R5", bit_of(11), 0, 0, 0, 0, 0, 0);
        chk("R5", "no escalation", 32'(disp_vec), 11);

        // R10 reset leaves shutdown
        step("R3", bit_of(0), 0, 0, 0, 0, 0, 0);
        step("R7", bit_of(1), 0, 0, 0, 0, 0, 0);
        chk("R7", "shutdown again", 32'(shutdown), 1);
        step("R10", '0, 0, 0, 0, 0, 0, 1);
        step("R10", '0, 0, 0, 0, 0, 0, 1);
        chk("R10", "reset exit", 32'(shutdown), 0);
        chk("R10", "pm cleared", 32'(prot_mode), 0);

        // R6 selector absent
        step("R6", bit_of(12), 77, 0, 0, 0, 0, 0);
        chk("R6", "no selector code", 32'(err_code), 0);
        chk("R6", "present", 32'(err_present), 1);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            logic [NVEC-1:0] rq = '0;
            int r = int'($urandom % 100);
            if (r >= 45) rq = bit_of(pool[$urandom % 8]);
            if (r >= 85) rq = rq | bit_of(pool[$urandom % 8]);
            if (r >= 97) rq = rq | bit_of(int'($urandom % 32));
            step("R2", rq, int'($urandom % 8192), 1'($urandom % 2),
                 ($urandom % 100) < 20, ($urandom % 100) < 15,
                 ($urandom % 100) < 5, ($urandom % 200) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule